// File: doc/BRIEF.md
# Decimal Record Down-Counter

This block keeps the number of records still to be processed in a repeated tape operation. It holds three decimal digits. Each digit is stored in a 1-to-10 code, so the code 10 stands for the digit zero and the code 0 never occurs. The count is zero only when every digit holds the code 10.

A load strobe takes a binary operand in the range 0 to 99999. The counter drops the operand's units digit. The next three decimal digits, from the tens upward, become the new count. A small sequencer does one divide-by-ten step per cycle and raises a busy output while it works. A load strobe that arrives while busy is ignored.

A decrement strobe lowers the count by one, borrowing across digits under the 1-to-10 code. A single-cycle done pulse follows any decrement that leaves the count at zero. A decrement of a count that is already zero leaves it unchanged and still pulses done. A decrement that arrives while a load is running is held and applied once the load has finished.

Top module: `rec_count`

## Requirements
- R1: After reset every digit holds code 10, `zero_o` is 1, and `busy_o` and `done_o` are 0.
- R2: `zero_o` is 1 exactly when all three digit codes in `cnt_o` equal 10. `cnt_o` packs digit i (i=0 tens, 1 hundreds, 2 thousands of the operand) in bits [4i+3:4i].
- R3: An accepted load keeps `busy_o` high for exactly NDIG+1 = 4 cycles. After that, digit i holds (op/10^(i+1)) mod 10, with a decimal 0 stored as code 10.
- R4: Every digit code is always in the range 1 to 10.
- R5: A decrement of a non-zero count lowers its decimal value by exactly one. A digit at code 10 becomes 9 and borrows from the next digit; a digit at code 1 becomes code 10.
- R6: `done_o` is high for one cycle, in the cycle after a decrement that leaves the count at zero, and at no other time.
- R7: A decrement of a zero count leaves all digits unchanged and still pulses `done_o`.
- R8: A decrement strobe that arrives while a load is busy is applied once, on the first cycle after `busy_o` falls.
- R9: A load strobe while `busy_o` is high has no effect on the load in progress or on its result.
- R10: Operand digits from the ten-thousands upward are dropped. For example, operand 12345 gives count 234.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load strobe |
| op_i | input | 17 | Binary load operand |
| dec_i | input | 1 | Decrement strobe |
| busy_o | output | 1 | Load sequencer working |
| zero_o | output | 1 | Count is zero |
| done_o | output | 1 | Pulse after a decrement that leaves the count at zero |
| cnt_o | output | 12 | Three digit codes, tens digit lowest |

## Verification
The bench loads each of the 1000 possible counts, using a varying units digit. A design that kept the units digit, or stored a raw 0, would fail this sweep. It then counts down from 999 to zero one step at a time, which exercises every borrow pattern. Here a wrong borrow rule would skip or repeat values, and a done pulse that fired early or late would show up. A decrement at zero is checked for an unchanged count, as is a decrement issued during a load; a design that dropped the held decrement would be off by one. The bench also checks that an overlapping load does not restart the sequencer and that operand digits above the thousands are discarded.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] dcode_t;
  localparam dcode_t ZERO_CODE = 4'd10;

  // Map a decimal digit 0..9 into the 1-to-10 code.
  function automatic dcode_t code_of(input logic [3:0] d);
    return (d == 4'd0) ? ZERO_CODE : d;
  endfunction

  // One downward step of a single coded digit (borrow handled by caller).
  function automatic dcode_t step_down(input dcode_t v);
    if (v == ZERO_CODE) return 4'd9;
    if (v == 4'd1)      return ZERO_CODE;
    return v - 4'd1;
  endfunction
endpackage

// File: rtl/rcnt_loader.sv
module rcnt_loader
  import rcnt_pkg::*;
#(
  parameter int NDIG = 3,
  parameter int OPW  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [OPW-1:0]   op_i,
  output logic             busy_o,
  output logic [NDIG-1:0]  we_o,
  output dcode_t           val_o
);
  localparam int PH_W = $clog2(NDIG + 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NDIG);

  logic [OPW-1:0]  work_q;
  logic [PH_W-1:0] phase_q;
  logic            busy_q;
  logic [OPW-1:0]  quot;
  logic [OPW-1:0]  rem;
  logic            accept;

  assign accept = ld_i && !busy_q;
  assign quot   = work_q / OPW'(10);
  assign rem    = work_q - quot * OPW'(10);
  assign val_o  = code_of(rem[3:0]);
  assign busy_o = busy_q;

  always_comb begin
    we_o = '0;
    if (busy_q && phase_q != '0)
      we_o[phase_q - PH_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      phase_q <= '0;
      busy_q  <= 1'b0;
    end else if (accept) begin
      work_q  <= op_i;
      phase_q <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      work_q <= quot;
      if (phase_q == LAST_PH) begin
        busy_q  <= 1'b0;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  // R3: sequence ends after its last phase
  p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q == LAST_PH) |=> !busy_q);
  // R3: an accepted strobe starts the sequencer
  p_load_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && phase_q == '0));
  // R9: a strobe during busy does not restart the phase count
  p_ignore_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ld_i && phase_q != LAST_PH) |=> (phase_q == $past(phase_q) + PH_W'(1)));
  // R4: the value written is always a legal code
  p_write_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_o) |-> (val_o != 4'd0 && val_o <= ZERO_CODE));
endmodule

// File: rtl/rcnt_digit.sv
module rcnt_digit
  import rcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we_i,
  input  dcode_t wval_i,
  input  logic   dec_en_i,
  output dcode_t val_o,
  output dcode_t nxt_o,
  output logic   is_ten_o
);
  dcode_t val_q;

  assign val_o    = val_q;
  assign is_ten_o = (val_q == ZERO_CODE);
  assign nxt_o    = we_i ? wval_i : (dec_en_i ? step_down(val_q) : val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= ZERO_CODE;
    else        val_q <= nxt_o;
  end

  // R4: code 0 never held, nothing above 10
  p_digit_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q != 4'd0) && (val_q <= ZERO_CODE));
  // R5: a digit at 10 steps to 9
  p_ten_to_nine_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en_i && !we_i && val_q == ZERO_CODE) |=> (val_q == 4'd9));
  // R5: a digit at 1 steps to code 10
  p_one_to_ten_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en_i && !we_i && val_q == 4'd1) |=> (val_q == ZERO_CODE));
  // R8: the load write and a decrement never meet on the same digit
  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && dec_en_i));
endmodule

// File: rtl/rec_count.sv
module rec_count
  import rcnt_pkg::*;
#(
  parameter int NDIG = 3,
  parameter int OPW  = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_i,
  input  logic [OPW-1:0]       op_i,
  input  logic                 dec_i,
  output logic                 busy_o,
  output logic                 zero_o,
  output logic                 done_o,
  output logic [NDIG*4-1:0]    cnt_o
);
  logic [NDIG-1:0] we;
  dcode_t          wval;
  logic            busy;
  logic [NDIG-1:0] ten;
  logic [NDIG-1:0] nxt_ten;
  logic [NDIG:0]   brw;
  logic [NDIG-1:0] dec_en;
  logic            zero_now;
  logic            zero_next;
  logic            dec_go;
  logic            pend_q;
  logic            done_q;
  logic            ld_acc;

  rcnt_loader #(.NDIG(NDIG), .OPW(OPW)) u_loader (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (ld_i),
    .op_i   (op_i),
    .busy_o (busy),
    .we_o   (we),
    .val_o  (wval)
  );

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    dcode_t v;
    dcode_t n;
    assign brw[i+1]   = brw[i] & ten[i];
    assign dec_en[i]  = dec_go & ~zero_now & brw[i];
    assign nxt_ten[i] = (n == ZERO_CODE);
    assign cnt_o[4*i +: 4] = v;
    rcnt_digit u_dig (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (we[i]),
      .wval_i   (wval),
      .dec_en_i (dec_en[i]),
      .val_o    (v),
      .nxt_o    (n),
      .is_ten_o (ten[i])
    );
  end

  assign zero_now  = &ten;
  assign zero_next = &nxt_ten;
  assign ld_acc    = ld_i & ~busy;
  assign dec_go    = ~busy & ~ld_acc & (dec_i | pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= (pend_q | dec_i) & ~dec_go;
      done_q <= dec_go & (zero_now | zero_next);
    end
  end

  assign busy_o = busy;
  assign zero_o = zero_now;
  assign done_o = done_q;

  // R6: done only ever accompanies a zero count
  p_done_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> zero_now);
  // R7: decrement at zero leaves digits alone and pulses done
  p_zero_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_go && zero_now) |=> ($stable(cnt_o) && done_q));
  // R8: a held decrement is taken as soon as the sequencer is idle
  p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy && !ld_i) |=> !pend_q);
  // R6: done never lasts two cycles without a new decrement
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !dec_go) |=> !done_q);
endmodule

// File: tb/rec_count_test.sv
`timescale 1ns/1ps
module rec_count_test;
  localparam int NDIG = 3;
  localparam int OPW  = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_i = 1'b0;
  logic [OPW-1:0] op_i = '0;
  logic dec_i = 1'b0;
  logic busy_o, zero_o, done_o;
  logic [NDIG*4-1:0] cnt_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rec_count #(.NDIG(NDIG), .OPW(OPW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .op_i(op_i), .dec_i(dec_i),
    .busy_o(busy_o), .zero_o(zero_o), .done_o(done_o), .cnt_o(cnt_o)
  );

  function automatic logic [11:0] coded(input int n);
    logic [11:0] r;
    int p = n;
    for (int i = 0; i < 3; i++) begin
      int d = p % 10;
      r[4*i +: 4] = (d == 0) ? 4'd10 : 4'(d);
      p = p / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int op, output int bcyc);
    @(negedge clk); ld_i = 1'b1; op_i = OPW'(op);
    @(negedge clk); ld_i = 1'b0;
    bcyc = 0;
    while (busy_o && bcyc < 20) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  task automatic decr();
    @(negedge clk); dec_i = 1'b1;
    @(negedge clk); dec_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bc;
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cnt_o == 12'haaa, "R1 cnt", int'(cnt_o), 12'haaa);
    chk(zero_o && !busy_o && !done_o, "R1 flags", {zero_o, busy_o, done_o}, 4);
    rst_n = 1'b1;

    // R3 / R2 / R4 sweep of every count with varying units digit
    bad = 0;
    for (int n = 0; n < 1000; n++) begin
      load(n * 10 + (n * 7) % 10, bc);
      if (bc != 4) begin bad++; chk(0, "R3 busy length", bc, 4); end
      if (cnt_o != coded(n)) begin bad++; chk(0, "R3 digits", int'(cnt_o), int'(coded(n))); end
      if (zero_o != (n == 0)) begin bad++; chk(0, "R2 zero", zero_o, n == 0); end
    end
    chk(bad == 0, "R3 load sweep", bad, 0);

    // R5 / R6 full countdown from 999
    load(9990, bc);
    bad = 0;
    for (int n = 999; n > 0; n--) begin
      decr();
      if (cnt_o != coded(n - 1)) begin bad++; chk(0, "R5 step", int'(cnt_o), int'(coded(n - 1))); end
      if (done_o != (n == 1)) begin bad++; chk(0, "R6 done", done_o, n == 1); end
      if (zero_o != (n == 1)) begin bad++; chk(0, "R2 zero", zero_o, n == 1); end
    end
    chk(bad == 0, "R5 countdown", bad, 0);
    @(negedge clk);
    chk(!done_o, "R6 done falls", done_o, 0);

    // R7 decrement at zero
    decr();
    chk(cnt_o == 12'haaa, "R7 unchanged", int'(cnt_o), 12'haaa);
    chk(done_o, "R7 done", done_o, 1);
    @(negedge clk);
    chk(!done_o, "R7 done falls", done_o, 0);

    // R8 decrement during busy
    @(negedge clk); ld_i = 1'b1; op_i = OPW'(1230);
    @(negedge clk); ld_i = 1'b0; dec_i = 1'b1;
    @(negedge clk); dec_i = 1'b0;
    bc = 0;
    while (busy_o && bc < 20) begin bc++; @(negedge clk); end
    chk(cnt_o == coded(123), "R8 loaded first", int'(cnt_o), int'(coded(123)));
    @(negedge clk);
    chk(cnt_o == coded(122), "R8 held applied", int'(cnt_o), int'(coded(122)));
    @(negedge clk);
    chk(cnt_o == coded(122), "R8 applied once", int'(cnt_o), int'(coded(122)));
    chk(!done_o, "R8 no done", done_o, 0);

    // R9 load during busy ignored
    @(negedge clk); ld_i = 1'b1; op_i = OPW'(4560);
    @(negedge clk); op_i = OPW'(7890);
    @(negedge clk); ld_i = 1'b0;
    bc = 0;
    while (busy_o && bc < 20) begin bc++; @(negedge clk); end
    chk(cnt_o == coded(456), "R9 reload ignored", int'(cnt_o), int'(coded(456)));

    // R10 upper digits dropped
    load(12345, bc);
    chk(cnt_o == coded(234), "R10 12345", int'(cnt_o), int'(coded(234)));
    load(99999, bc);
    chk(cnt_o == coded(999), "R10 99999", int'(cnt_o), int'(coded(999)));
    load(10009, bc);
    chk(cnt_o == 12'haaa && zero_o, "R10 10009", int'(cnt_o), 12'haaa);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule